// File: doc/BRIEF.md
# Sensor Serial Slave with Trim Command Decode

This block is the serial port of a field-sensing converter. A host drives a chip-select (active low), a serial clock and a data line. The block answers on a data output that it releases while it is not selected. A frame whose first data bit is 0 is a read: the block shifts out the most recent conversion result, right-aligned in a 16-clock frame. A frame that opens with the bits 1, 0 is a write. It carries a 3-bit filter code, a 6-bit gain trim and a burn flag.

A write is only decoded when chip-select rises, and only if the frame had exactly 16 clocks and a valid prefix. The decoded trim is held in a pending register and becomes the live trim when the front end next reports the end of a conversion. When the burn flag is set, the pending value is also armed for one-time programming. The fuse array is modelled as sticky flip-flops that can only gain ones. It is ORed with the armed value when chip-select falls at the start of the following frame, and the block emits a one-cycle burn pulse at that moment. After every reset the live trim is reloaded from the fuse array.

All pins are sampled by the block clock. A one-stage edge detector feeds the frame state machine. Its states are LOAD (copy the fuse array to the live trim, taken once after reset), IDLE (deselected), FRAME (selected, shifting) and COMMIT (decode the finished frame). Its transitions are: LOAD→IDLE unconditionally; IDLE→FRAME on a chip-select fall; FRAME→COMMIT on a chip-select rise; COMMIT→IDLE unconditionally.

Top module: `fs_slave`

## Requirements
- R1: The data input is captured on the rising serial clock edge. The data output changes only after a falling serial clock edge, so it holds the same value across each high phase. The first bit is presented before the first rising edge.
- R2: While chip-select is high, `sdo_oe` is 0 (the output driver is released). Whenever `sdo_oe` is 0, `sdo` is 0. `sdo_oe` is 1 throughout a selected frame.
- R3: While chip-select is high, activity on the serial clock and data input changes neither the live trim nor the next read result.
- R4: Each `conv_done` pulse stores `conv_data`. On a chip-select fall, the stored value is loaded for output. The frame then shifts out four 0 bits, followed by the 12 result bits, MSB first.
- R5: A write frame has bit 15 = 1 and bit 14 = 0, with bits sent MSB first. Bits 13:11 are the filter code and bits 10:5 are the gain trim. Bits 4:1 are don't-care and bit 0 is the burn flag. The frame is decoded on the chip-select rise.
- R6: A decoded write leaves `filt_code`/`gain_trim` unchanged until the next `conv_done` pulse. That pulse makes it live one cycle later.
- R7: A frame with a clock count other than 16, or with a prefix other than 1, 0, changes nothing.
- R8: A write with burn flag 0 is a preview only: after a reset the live trim comes back to the fuse contents.
- R9: A write with burn flag 1 produces exactly one `otp_fire` pulse, at the chip-select fall of the next frame and not before. At that same moment it ORs its filter and gain into the fuse array.
- R10: Fuse bits only go from 0 to 1. Burning a second value leaves the OR of both values. The array is cleared only by `blank_n`.
- R11: During reset the live trim is 0. In the first cycle after reset is released it is loaded from the fuse array.
- R12: If several writes are decoded before a conversion ends, the last one becomes live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| blank_n | input | 1 | Clears the modelled fuse array (unprogrammed part), active low |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, 0 when released |
| sdo_oe | output | 1 | Output driver enable for `sdo` (tri-state control) |
| conv_done | input | 1 | One-cycle end-of-conversion strobe from the front end |
| conv_data | input | 12 | Conversion result, valid with `conv_done` |
| filt_code | output | 3 | Live filter code |
| gain_trim | output | 6 | Live gain trim |
| otp_fire | output | 1 | One-cycle fuse programming pulse |

## Verification
The checker follows the cycle-level rules on every clock. After chip-select has stayed high long enough, the driver must be released. A released output must be 0. The live trim may move only after a conversion strobe or the post-reset load. A burn pulse stands alone and falls inside a selected frame. The fuse array never loses a bit. Frame contents can only be shown by the bench's scenarios: the shifted result and the stability of each bit across the high phase, the decode of write fields, the rejection of short, long or mis-prefixed frames, and last-write-wins. The same holds for the one-frame delay of the burn pulse and the OR of two burns, which is seen through the reload after reset.

// File: rtl/fsense_pkg.sv
package fsense_pkg;
    localparam int FILT_W = 3;
    localparam int GAIN_W = 6;
    localparam int FUSE_W = FILT_W + GAIN_W;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_IDLE,
        ST_FRAME,
        ST_COMMIT
    } link_state_e;

    typedef struct packed {
        logic [FILT_W-1:0] filt;
        logic [GAIN_W-1:0] gain;
    } trim_t;
endpackage

// File: rtl/fs_edge.sv
module fs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_bit
);
    logic cs_s, cs_p, sck_s, sck_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s    <= 1'b1;
            cs_p    <= 1'b1;
            sck_s   <= 1'b0;
            sck_p   <= 1'b0;
            sdi_bit <= 1'b0;
        end else begin
            cs_s    <= cs_n;
            cs_p    <= cs_s;
            sck_s   <= sck;
            sck_p   <= sck_s;
            sdi_bit <= sdi;
        end
    end

    assign cs_fall  = cs_p & ~cs_s;
    assign cs_rise  = ~cs_p & cs_s;
    assign sck_rise = ~sck_p & sck_s;
    assign sck_fall = sck_p & ~sck_s;
endmodule

// File: rtl/fs_shift.sv
module fs_shift #(
    parameter int FRAME_LEN = 16,
    parameter int DATA_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_done,
    input  logic [DATA_W-1:0]    conv_data,
    input  logic                 frame_start,
    input  logic                 bit_in_en,
    input  logic                 bit_out_en,
    input  logic                 sdi_bit,
    output logic [FRAME_LEN-1:0] rx_word,
    output logic                 len_ok,
    output logic                 tx_bit
);
    localparam int CNT_W = $clog2(FRAME_LEN + 2);
    localparam int PAD_W = FRAME_LEN - DATA_W;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);

    logic [DATA_W-1:0]    result_q;
    logic [FRAME_LEN-1:0] tx_q;
    logic [FRAME_LEN-1:0] tx_init;
    logic [CNT_W-1:0]     cnt_q;

    generate
        if (PAD_W > 0) begin : g_pad
            assign tx_init = {{PAD_W{1'b0}}, result_q};
        end else begin : g_nopad
            assign tx_init = result_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            tx_q     <= '0;
            rx_word  <= '0;
            cnt_q    <= '0;
        end else begin
            if (conv_done) result_q <= conv_data;
            if (frame_start) begin
                tx_q    <= tx_init;
                rx_word <= '0;
                cnt_q   <= '0;
            end else begin
                if (bit_in_en) begin
                    rx_word <= {rx_word[FRAME_LEN-2:0], sdi_bit};
                    if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
                end
                if (bit_out_en) tx_q <= {tx_q[FRAME_LEN-2:0], 1'b0};
            end
        end
    end

    assign len_ok = (cnt_q == CNT_FULL);
    assign tx_bit = tx_q[FRAME_LEN-1];
endmodule

// File: rtl/fs_trim.sv
module fs_trim
    import fsense_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  blank_n,
    input  logic  load_en,
    input  logic  commit_en,
    input  logic  frame_start,
    input  logic  conv_done,
    input  trim_t wr_trim,
    input  logic  wr_burn,
    output trim_t act_trim,
    output trim_t fuse_trim,
    output logic  otp_fire
);
    trim_t pend_q, arm_q;
    logic  pend_v, arm_v, fire_now;

    assign fire_now = frame_start & arm_v;

    always_ff @(posedge clk or negedge blank_n) begin
        if (!blank_n)      fuse_trim <= '0;
        else if (fire_now) fuse_trim <= fuse_trim | arm_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_trim <= '0;
            pend_q   <= '0;
            pend_v   <= 1'b0;
            arm_q    <= '0;
            arm_v    <= 1'b0;
            otp_fire <= 1'b0;
        end else begin
            otp_fire <= fire_now;
            if (load_en)                act_trim <= fuse_trim;
            else if (conv_done && pend_v) act_trim <= pend_q;
            if (conv_done) pend_v <= 1'b0;
            if (commit_en) begin
                pend_q <= wr_trim;
                pend_v <= 1'b1;
            end
            if (fire_now) arm_v <= 1'b0;
            if (commit_en && wr_burn) begin
                arm_q <= wr_trim;
                arm_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fs_slave.sv
module fs_slave
    import fsense_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int FRAME_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic [FILT_W-1:0] filt_code,
    output logic [GAIN_W-1:0] gain_trim,
    output logic              otp_fire
);
    localparam int FILT_LSB = FRAME_LEN - 2 - FILT_W;
    localparam int GAIN_LSB = FILT_LSB - GAIN_W;

    link_state_e state_q, state_d;
    logic cs_fall, cs_rise, sck_rise, sck_fall, sdi_bit;
    logic frame_start, commit_en, load_en, bit_in_en, bit_out_en;
    logic [FRAME_LEN-1:0] rx_word;
    logic len_ok, tx_bit, prefix_ok;
    trim_t wr_trim, act_trim, fuse_trim;

    fs_edge u_edge (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .sdi_bit(sdi_bit)
    );

    fs_shift #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .frame_start(frame_start), .bit_in_en(bit_in_en), .bit_out_en(bit_out_en),
        .sdi_bit(sdi_bit), .rx_word(rx_word), .len_ok(len_ok), .tx_bit(tx_bit)
    );

    assign prefix_ok    = (rx_word[FRAME_LEN-1 -: 2] == 2'b10);
    assign wr_trim.filt = rx_word[FILT_LSB +: FILT_W];
    assign wr_trim.gain = rx_word[GAIN_LSB +: GAIN_W];

    fs_trim u_trim (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .load_en(load_en),
        .commit_en(commit_en), .frame_start(frame_start), .conv_done(conv_done),
        .wr_trim(wr_trim), .wr_burn(rx_word[0]), .act_trim(act_trim),
        .fuse_trim(fuse_trim), .otp_fire(otp_fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   state_d = ST_IDLE;
            ST_IDLE:   if (cs_fall) state_d = ST_FRAME;
            ST_FRAME:  if (cs_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en     = (state_q == ST_LOAD);
        frame_start = (state_q == ST_IDLE) && cs_fall;
        sdo_oe      = (state_q == ST_FRAME);
        bit_in_en   = sdo_oe && sck_rise;
        bit_out_en  = sdo_oe && sck_fall;
        commit_en   = (state_q == ST_COMMIT) && len_ok && prefix_ok;
    end

    assign sdo       = sdo_oe & tx_bit;
    assign filt_code = act_trim.filt;
    assign gain_trim = act_trim.gain;
endmodule

// File: rtl/fs_slave_chk.sv
module fs_slave_chk
    import fsense_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              blank_n,
    input logic              cs_n,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              conv_done,
    input logic [FILT_W-1:0] filt_code,
    input logic [GAIN_W-1:0] gain_trim,
    input logic              otp_fire,
    input logic [FUSE_W-1:0] fuse_bits
);
    // R2
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !sdo_oe);

    // R2
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    // R6
    trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) && !$past(conv_done) |-> $stable({filt_code, gain_trim}));

    // R9
    fire_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_fire |-> sdo_oe);

    // R9
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_fire |=> !otp_fire);

    // R10
    fuse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_n && $past(blank_n) |-> (($past(fuse_bits) & ~fuse_bits) == '0));
endmodule

bind fs_slave fs_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .cs_n(cs_n), .sdo(sdo),
    .sdo_oe(sdo_oe), .conv_done(conv_done), .filt_code(filt_code),
    .gain_trim(gain_trim), .otp_fire(otp_fire), .fuse_bits(fuse_trim)
);

// File: tb/tb_fs_slave.sv
module tb_fs_slave;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, blank_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic sdo, sdo_oe, otp_fire;
    logic [2:0] filt_code;
    logic [5:0] gain_trim;

    int checks = 0, errs = 0, fire_cnt = 0, exp_fire = 0;
    bit done = 0;
    logic [8:0]  m_act = '0, m_pend = '0, m_fuse = '0, m_armv = '0;
    bit          m_pv = 0, m_arm = 0;
    logic [11:0] m_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n && otp_fire) fire_cnt++;

    fs_slave dut (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .cs_n(cs_n), .sck(sck),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .conv_done(conv_done),
        .conv_data(conv_data), .filt_code(filt_code), .gain_trim(gain_trim),
        .otp_fire(otp_fire)
    );

    function automatic logic [15:0] wr_word(logic [2:0] f, logic [5:0] g, logic burn);
        return {2'b10, f, g, 4'b0000, burn};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_trim(input string tag);
        chk({filt_code, gain_trim} === m_act, tag, {7'b0, filt_code, gain_trim}, {7'b0, m_act});
    endtask

    task automatic run_frame(input logic [15:0] word, input int nclk, input bit is_read);
        logic [15:0] pre, post;
        bit oe_ok;
        pre = '0; post = '0; oe_ok = 1;
        if (m_arm) begin m_fuse |= m_armv; m_arm = 0; exp_fire++; end
        cs_n = 1'b0;
        idle(4);
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 16) ? word[15-i] : 1'b0;
            idle(4);
            if (i < 16) pre[15-i] = sdo;
            oe_ok &= sdo_oe;
            sck = 1'b1;
            idle(4);
            if (i < 16) post[15-i] = sdo;
            sck = 1'b0;
        end
        idle(4);
        cs_n = 1'b1;
        idle(6);
        chk(oe_ok == 1, "R2 oe during frame", {15'b0, oe_ok}, 16'h1);
        chk(fire_cnt == exp_fire, "R9 fire count", fire_cnt[15:0], exp_fire[15:0]);
        if (is_read) begin
            chk(pre === {4'b0, m_res}, "R4 R1 read data", pre, {4'b0, m_res});
            chk(post === pre, "R1 sdo held over high phase", post, pre);
        end
        if (nclk == 16 && word[15:14] == 2'b10) begin
            m_pend = word[13:5];
            m_pv = 1;
            if (word[0]) begin m_arm = 1; m_armv = word[13:5]; end
        end
    endtask

    task automatic conv(input logic [11:0] d);
        conv_data = d;
        conv_done = 1'b1;
        idle(1);
        conv_done = 1'b0;
        idle(2);
        m_res = d;
        if (m_pv) begin m_act = m_pend; m_pv = 0; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        chk({filt_code, gain_trim} == 9'd0, "R11 trim zero in reset", {7'b0, filt_code, gain_trim}, 16'h0);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R2 released in reset", {14'b0, sdo_oe, sdo}, 16'h0);
        rst_n = 1'b1;
        idle(3);
        m_act = m_fuse; m_pv = 0; m_arm = 0; m_res = '0;
        chk_trim("R11 R8 reload from fuses");
    endtask

    initial begin
        logic [15:0] w;
        void'($urandom(32'd2417));
        idle(4);
        blank_n = 1'b1;
        do_reset();

        // R3: serial pins active while deselected
        conv(12'hABC);
        for (int i = 0; i < 20; i++) begin
            sck = ~sck; sdi = $urandom_range(1, 0); idle(2);
            chk(sdo_oe == 1'b0 && sdo == 1'b0, "R2 R3 released while deselected", {14'b0, sdo_oe, sdo}, 16'h0);
        end
        sck = 1'b0; sdi = 1'b0; idle(4);
        chk_trim("R3 trim untouched by deselected clocks");
        run_frame(16'h0000, 16, 1);

        // random reads and previews (R4 R5 R6)
        for (int n = 0; n < 40; n++) begin
            if ($urandom_range(1, 0) == 0) begin
                conv(12'($urandom));
                w = {1'b0, 15'($urandom)};
                run_frame(w, 16, 1);
            end else begin
                w = wr_word(3'($urandom), 6'($urandom), 1'b0);
                run_frame(w, 16, 0);
                chk_trim("R6 trim held until conversion");
                conv(12'($urandom));
                chk_trim("R5 R6 write live after conversion");
            end
        end

        // R12: last write wins
        run_frame(wr_word(3'd5, 6'd9, 1'b0), 16, 0);
        run_frame(wr_word(3'd2, 6'd40, 1'b0), 16, 0);
        chk_trim("R12 held before conversion");
        conv(12'h123);
        chk_trim("R12 last write live");

        // R7: malformed frames
        run_frame({2'b11, 3'd7, 6'd63, 5'b0}, 16, 0);
        run_frame(wr_word(3'd1, 6'd1, 1'b0), 15, 0);
        run_frame(wr_word(3'd6, 6'd7, 1'b0), 17, 0);
        run_frame({2'b00, 3'd4, 6'd12, 5'b0}, 16, 1);
        conv(12'h456);
        chk_trim("R7 malformed frames ignored");

        // R8: preview lost across reset
        run_frame(wr_word(3'd7, 6'd63, 1'b0), 16, 0);
        conv(12'h789);
        chk_trim("R8 preview live");
        do_reset();

        // R9: first burn
        run_frame(wr_word(3'd1, 6'd3, 1'b1), 16, 0);
        chk(fire_cnt == exp_fire, "R9 no fire before next frame", fire_cnt[15:0], exp_fire[15:0]);
        conv(12'h0F0);
        chk_trim("R9 burn value live as preview");
        run_frame(16'h0000, 16, 1);
        run_frame(wr_word(3'd0, 6'd0, 1'b0), 16, 0);
        do_reset();
        chk({filt_code, gain_trim} == 9'b001_000011, "R9 fused value reloads", {7'b0, filt_code, gain_trim}, 16'h043);

        // R10: second burn ORs in
        run_frame(wr_word(3'd2, 6'd32, 1'b1), 16, 0);
        run_frame(16'h0000, 16, 1);
        do_reset();
        chk({filt_code, gain_trim} == 9'b011_100011, "R10 fuse OR", {7'b0, filt_code, gain_trim}, 16'h0E3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    end
endmodule